// File: doc/BRIEF.md
# Microcontroller Program Download Port

This block gives a host a single 32-bit control/status word through which it fills the byte-wide program memory of an embedded microcontroller core. The core is held in reset while the host loads the memory. Each host write carries three fields. The top byte is a control code, the next byte is a data byte, and the low half-word holds a byte address. While upload mode is active, a write stores its data byte in program memory. A read returns the word last written.

In upload mode every host read also moves the address field on by one. The data field then shows the stored byte at the new address. This lets the host stream the whole image back and compare it with what it sent. Address bits above the pointer width are cleared when the pointer advances, so the host drops them in its comparisons.

A finishing write releases the core and latches the image size. The core then fetches its program through a separate read port.

Top module: `prog_dl_port`

## Requirements
- R1: After reset, `reg_rdata_o` is 0x00000000 (control code 0x00), `core_rst_o` is 1 and `size_o` is 0.
- R2: A write whose top byte [31:24] is 0x0F enters upload mode: `core_rst_o` is 1 and the top byte of `reg_rdata_o` reads 0x0F.
- R3: After any write, `reg_rdata_o` equals the written 32-bit word (code in [31:24], data in [23:16], address field in [15:0]).
- R4: A read strobe in upload mode advances the address field on the next cycle. The new field is (addr[13:0]+1) with bits [15:14] forced to 0. The data field then shows the program byte stored at the new address.
- R5: The address pointer wraps from 0x3FFF to 0x0000.
- R6: A read strobe while the control code is not 0x0F leaves `reg_rdata_o` unchanged.
- R7: A write whose control code is not 0x0F does not change program memory.
- R8: A write whose code has bit 0 and bit 1 set and bit 3 clear (for example 0x03 or 0x13) sets `core_rst_o` to 0 and latches `size_o` = wdata[15:0]. Any other non-0x0F code leaves `core_rst_o` and `size_o` unchanged.
- R9: The fetch port returns the byte stored at `fetch_addr_i` one clock later. Memory is indexed by the low `MEM_AW` address bits.
- R10: When a write and a read strobe arrive in the same cycle, the write takes effect and the pointer does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Host write strobe |
| reg_re_i | input | 1 | Host read strobe |
| reg_wdata_i | input | 32 | Host write word: code, data byte, address |
| reg_rdata_o | output | 32 | Register read-back word |
| core_rst_o | output | 1 | Reset to the microcontroller core |
| size_o | output | 16 | Image size latched by the last finishing write |
| fetch_addr_i | input | MEM_AW | Core program fetch address |
| fetch_data_o | output | 8 | Core program fetch data |

## Verification
The bench builds the block with `MEM_AW` = 8, so the program memory is 256 bytes, while the pointer keeps its 14-bit width. With these values, a write at 0x3FFF lands in real storage and its following read wraps to address 0. A loaded image can be walked back byte by byte in a few hundred cycles. An address with bits 15:14 set can be checked to resolve to the same byte as the plain address.

// File: rtl/prog_dl_pkg.sv
package prog_dl_pkg;
  localparam logic [7:0] CODE_UPLOAD = 8'h0F;

  typedef struct packed {
    logic [7:0]  code;
    logic [7:0]  data;
    logic [15:0] addr;
  } dl_word_t;

  function automatic logic is_release(input logic [7:0] c);
    return c[0] & c[1] & ~c[3];
  endfunction
endpackage

// File: rtl/prog_ram.sv
module prog_ram #(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic          ra_en_i,
  input  logic [AW-1:0] ra_addr_i,
  output logic [7:0]    ra_data_o,
  input  logic [AW-1:0] rb_addr_i,
  output logic [7:0]    rb_data_o
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i) begin
    if (ra_en_i) ra_data_o <= mem_q[ra_addr_i];
  end

  always_ff @(posedge clk_i) begin
    rb_data_o <= mem_q[rb_addr_i];
  end
endmodule

// File: rtl/dl_ctrl_reg.sv
module dl_ctrl_reg
  import prog_dl_pkg::*;
#(
  parameter int PTR_W  = 14,
  parameter int MEM_AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [31:0]       wdata_i,
  input  logic [7:0]        ram_rdata_i,
  output logic              ram_we_o,
  output logic [MEM_AW-1:0] ram_waddr_o,
  output logic [7:0]        ram_wdata_o,
  output logic              ram_ren_o,
  output logic [MEM_AW-1:0] ram_raddr_o,
  output logic [31:0]       rdata_o,
  output logic              core_rst_o,
  output logic [15:0]       size_o
);
  localparam int PAD = 16 - PTR_W;

  dl_word_t          word_q, wr_word;
  logic              from_ram_q;
  logic              upload, advance;
  logic [PTR_W-1:0]  next_ptr;

  assign wr_word  = dl_word_t'(wdata_i);
  assign upload   = (word_q.code == CODE_UPLOAD);
  assign advance  = re_i & ~we_i & upload;
  assign next_ptr = word_q.addr[PTR_W-1:0] + 1'b1;

  assign ram_we_o    = we_i & (wr_word.code == CODE_UPLOAD);
  assign ram_waddr_o = wr_word.addr[MEM_AW-1:0];
  assign ram_wdata_o = wr_word.data;
  assign ram_ren_o   = advance;
  assign ram_raddr_o = next_ptr[MEM_AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q     <= '0;
      from_ram_q <= 1'b0;
      core_rst_o <= 1'b1;
      size_o     <= '0;
    end else if (we_i) begin
      word_q     <= wr_word;
      from_ram_q <= 1'b0;
      if (wr_word.code == CODE_UPLOAD) begin
        core_rst_o <= 1'b1;
      end else if (is_release(wr_word.code)) begin
        core_rst_o <= 1'b0;
        size_o     <= wr_word.addr;
      end
    end else if (advance) begin
      // upper address bits beyond the pointer are dropped on each step
      word_q.addr <= {{PAD{1'b0}}, next_ptr};
      from_ram_q  <= 1'b1;
    end
  end

  assign rdata_o = {word_q.code, from_ram_q ? ram_rdata_i : word_q.data, word_q.addr};
endmodule

// File: rtl/prog_dl_port.sv
module prog_dl_port #(
  parameter int MEM_AW = 10,
  parameter int PTR_W  = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              core_rst_o,
  output logic [15:0]       size_o,
  input  logic [MEM_AW-1:0] fetch_addr_i,
  output logic [7:0]        fetch_data_o
);
  logic              ram_we, ram_ren;
  logic [MEM_AW-1:0] ram_waddr, ram_raddr;
  logic [7:0]        ram_wdata, ram_rdata;

  dl_ctrl_reg #(.PTR_W(PTR_W), .MEM_AW(MEM_AW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .re_i        (reg_re_i),
    .wdata_i     (reg_wdata_i),
    .ram_rdata_i (ram_rdata),
    .ram_we_o    (ram_we),
    .ram_waddr_o (ram_waddr),
    .ram_wdata_o (ram_wdata),
    .ram_ren_o   (ram_ren),
    .ram_raddr_o (ram_raddr),
    .rdata_o     (reg_rdata_o),
    .core_rst_o  (core_rst_o),
    .size_o      (size_o)
  );

  prog_ram #(.AW(MEM_AW)) u_ram (
    .clk_i     (clk_i),
    .we_i      (ram_we),
    .waddr_i   (ram_waddr),
    .wdata_i   (ram_wdata),
    .ra_en_i   (ram_ren),
    .ra_addr_i (ram_raddr),
    .ra_data_o (ram_rdata),
    .rb_addr_i (fetch_addr_i),
    .rb_data_o (fetch_data_o)
  );
endmodule

// File: rtl/prog_dl_port_chk.sv
module prog_dl_port_chk #(
  parameter int PTR_W = 14
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic        reg_re_i,
  input logic [31:0] reg_wdata_i,
  input logic [31:0] reg_rdata_o,
  input logic        core_rst_o,
  input logic [15:0] size_o
);
  logic upl;
  assign upl = (reg_rdata_o[31:24] == 8'h0F);

  AST_UPLOAD_HOLDS_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upl |-> core_rst_o); // R2

  AST_WRITE_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> reg_rdata_o == $past(reg_wdata_i)); // R3 R10

  AST_READ_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && !reg_we_i && upl) |=>
      (reg_rdata_o[PTR_W-1:0] == $past(reg_rdata_o[PTR_W-1:0]) + 1'b1) &&
      (reg_rdata_o[15:PTR_W] == '0)); // R4 R5

  AST_IDLE_READ_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && !reg_we_i && !upl) |=> $stable(reg_rdata_o)); // R6

  AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_wdata_i[24] && reg_wdata_i[25] && !reg_wdata_i[27]) |=>
      (!core_rst_o && size_o == $past(reg_wdata_i[15:0]))); // R8

  AST_SIZE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_we_i |=> $stable(size_o) && $stable(core_rst_o)); // R8
endmodule

bind prog_dl_port prog_dl_port_chk #(.PTR_W(PTR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_re_i    (reg_re_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .core_rst_o  (core_rst_o),
  .size_o      (size_o)
);

// File: tb/prog_dl_port_test.sv
module prog_dl_port_test;
  localparam int AW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we_i = 1'b0;
  logic          reg_re_i = 1'b0;
  logic [31:0]   reg_wdata_i = '0;
  logic [31:0]   reg_rdata_o;
  logic          core_rst_o;
  logic [15:0]   size_o;
  logic [AW-1:0] fetch_addr_i = '0;
  logic [7:0]    fetch_data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  prog_dl_port #(.MEM_AW(AW), .PTR_W(14)) uut (.*);

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 8'hFF);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] w);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_wdata_i = w;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(output logic [31:0] v);
    @(negedge clk_i);
    v = reg_rdata_o;
    reg_re_i = 1'b1;
    @(negedge clk_i);
    reg_re_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 rdata", reg_rdata_o, 32'h0);
    chk("R1 core_rst", 32'(core_rst_o), 32'h1);
    chk("R1 size", 32'(size_o), 32'h0);
  endtask

  task automatic t_load;
    wr(32'h0F00_0000);
    chk("R2 code", 32'(reg_rdata_o[31:24]), 32'h0F);
    chk("R2 core_rst", 32'(core_rst_o), 32'h1);
    for (int i = 0; i < 16; i++) wr({8'h0F, pat(i), 16'(i)});
    chk("R3 echo", reg_rdata_o, {8'h0F, pat(15), 16'h000F});
  endtask

  task automatic t_walk;
    logic [31:0] v;
    wr(32'h0FA5_3FFF);
    rd(v);
    chk("R3 echo before read", v, 32'h0FA5_3FFF);
    chk("R5 wrap", reg_rdata_o, {8'h0F, pat(0), 16'h0000});
    for (int i = 1; i < 16; i++) begin
      rd(v);
      chk("R4 walk", reg_rdata_o, {8'h0F, pat(i), 16'(i)});
    end
    wr({8'h0F, pat(4), 16'hC004});
    rd(v);
    chk("R4 high bits echoed", v, {8'h0F, pat(4), 16'hC004});
    chk("R4 high bits cleared", reg_rdata_o, {8'h0F, pat(5), 16'h0005});
  endtask

  task automatic t_foreign;
    logic [31:0] v;
    wr(32'h01EE_0003);
    rd(v);
    chk("R6 read no advance", reg_rdata_o, 32'h01EE_0003);
    chk("R6 core_rst held", 32'(core_rst_o), 32'h1);
    wr({8'h0F, pat(2), 16'h0002});
    rd(v);
    chk("R7 ram untouched", reg_rdata_o, {8'h0F, pat(3), 16'h0003});
  endtask

  task automatic t_collide;
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_re_i = 1'b1; reg_wdata_i = 32'h0F5A_0020;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_re_i = 1'b0;
    chk("R10 write wins", reg_rdata_o, 32'h0F5A_0020);
  endtask

  task automatic t_fetch;
    fetch_addr_i = 8'd5;
    @(negedge clk_i);
    chk("R9 fetch 5", 32'(fetch_data_o), 32'(pat(5)));
    fetch_addr_i = 8'hFF;
    @(negedge clk_i);
    chk("R9 fetch alias 3FFF", 32'(fetch_data_o), 32'hA5);
  endtask

  task automatic t_release;
    wr(32'h0300_0010);
    chk("R8 release rst", 32'(core_rst_o), 32'h0);
    chk("R8 size", 32'(size_o), 32'h10);
    wr(32'h0B00_0020);
    chk("R8 bit3 code rst", 32'(core_rst_o), 32'h0);
    chk("R8 bit3 code size", 32'(size_o), 32'h10);
    wr(32'h1300_0011);
    chk("R8 checked size", 32'(size_o), 32'h11);
    chk("R8 checked rst", 32'(core_rst_o), 32'h0);
    wr(32'h0F00_0000);
    chk("R2 re-enter rst", 32'(core_rst_o), 32'h1);
    chk("R8 size kept", 32'(size_o), 32'h11);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_load();
    t_walk();
    t_foreign();
    t_collide();
    t_fetch();
    t_release();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule